// File: doc/BRIEF.md
# Wide Register Subword Access Block

This block is a small register file whose registers are wider than the CPU bus that reaches them. The data bus is 16 bits wide. Each register is split into 16-bit subwords, and every subword has its own byte address. A 64-bit control register and a 64-bit status register each take four subwords. A 32-bit configuration register takes two. Software reaches any bit by addressing the subword that contains it.

An accepted bus request is decoded into one strobe per subword. On a write, the strobe of the addressed subword loads every writable field that lies in that subword. Each field takes its own slice of the bus data and bit enables, with the slice shifted down by the subword's bit offset. On a read, a full image of the register is built from its fields, with zeros in every unused bit, and the addressed 16-bit window of that image is returned. A read-only status field may straddle a subword boundary. Its low bits then appear in the upper part of the earlier subword, and its remaining bits continue from bit 0 of the next one.

The bus is handled by a two-state machine. In `ST_IDLE`, `req_ready` is high. The transition "accept" (`req_valid` high) moves it to `ST_RESP`, where `rsp_valid` is high and the registered read word is presented. The transition "retire" (`rsp_ready` high) returns it to `ST_IDLE`.

Top module: `wsub_regblock`

## Requirements
- R1: While `rst` is high at a clock edge, all writable fields clear to 0 and the machine enters `ST_IDLE` (`req_ready`=1, `rsp_valid`=0).
- R2: Subword i of a register sits at byte address base+2*i. The bases are: control at 0x00, status at 0x08, configuration at 0x10. A write changes only the fields inside the addressed subword.
- R3: A write updates a field bit only where the matching bus bit enable is 1. Field bits with enable 0 keep their value.
- R4: Control fields sit at bits [7:0], [14:12], [36] and [47:40], and configuration high byte at bits [23:16]. A read returns the addressed 16-bit window of the register image, with every bit outside a field reading 0. For example, writing 0x1234, 0x5678, 0x9ABC and 0xDEF1 to 0x00, 0x02, 0x04 and 0x06 gives fields 0x34, 0x1, 0x1 and 0x9A, and reads of 0x1034, 0x0000, 0x9A10 and 0x0000.
- R5: The 20-bit status field at bits [31:12] spans two subwords. With inputs 0xABCDE and 3 (the second field at bits [49:48]), reads at 0x08, 0x0A, 0x0C and 0x0E return 0xE000, 0xABCD, 0x0000 and 0x0003.
- R6: The reversed configuration field occupies bus bits [11:4] of subword 0x10. Bus bit 4 maps to field bit 7, and bus bit 11 maps to field bit 0. Reads return the same bus pattern.
- R7: A request to an unmapped or odd address changes no field, and a read from such an address returns 0.
- R8: `sts_lo_acc` pulses for one cycle on every accepted read or write of subword 0x08 or 0x0A. Accesses to the other status subwords do not pulse it.
- R9: An accepted request gives `rsp_valid` in the next cycle. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold and `req_ready` stays low.
- R10: Writes to the status register have no effect, and its reads always reflect the hardware inputs sampled at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte address |
| req_wdata | input | 16 | Write data |
| req_biten | input | 16 | Per-bit write enable |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 16 | Read data (0 for writes) |
| ctl_f1 | output | 8 | Control field, bits [7:0] |
| ctl_f2 | output | 3 | Control field, bits [14:12] |
| ctl_f3 | output | 1 | Control field, bit [36] |
| ctl_f4 | output | 8 | Control field, bits [47:40] |
| cfg_rev | output | 8 | Reversed configuration field |
| cfg_hi | output | 8 | Configuration field, bits [23:16] |
| sts_lo_in | input | 20 | Status field value, bits [31:12] |
| sts_hi_in | input | 2 | Status field value, bits [49:48] |
| sts_lo_acc | output | 1 | Access pulse for the spanning status field |

## Verification
The bench targets the split status field. A design that forgets the shift into the following subword would return 0xBCDE or drop the upper nibble at 0x0A. It drives write sweeps with partial bit enables against an arithmetic model of each register image. This exposes a field slice that is not shifted down by its subword offset, which would corrupt the byte at [47:40], as well as a decoder that lets one subword's strobe reach another's fields. Odd and unmapped addresses are probed for stray updates or non-zero reads. The reversed field is checked with single-bit patterns, so a missing reversal shows up as 0x01 instead of 0x80. The access pulse is counted across all four status subwords to catch a strobe OR that uses the wrong range, and a stalled response checks that the read word does not follow live inputs.

// File: rtl/wsub_pkg.sv
package wsub_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int BUS_W     = 16;
    localparam int BUS_BYTES = BUS_W / 8;
    localparam int ADDR_W    = 6;

    // register widths and base byte addresses
    localparam int CTL_W    = 64;
    localparam int STS_W    = 64;
    localparam int CFG_W    = 32;
    localparam int CTL_BASE = 0;
    localparam int STS_BASE = 8;
    localparam int CFG_BASE = 16;
    localparam int CTL_NSUB = CTL_W / BUS_W;
    localparam int STS_NSUB = STS_W / BUS_W;
    localparam int CFG_NSUB = CFG_W / BUS_W;

    // field placement inside each register
    localparam int CTL_F1_LO = 0;   localparam int CTL_F1_W = 8;
    localparam int CTL_F2_LO = 12;  localparam int CTL_F2_W = 3;
    localparam int CTL_F3_LO = 36;  localparam int CTL_F3_W = 1;
    localparam int CTL_F4_LO = 40;  localparam int CTL_F4_W = 8;
    localparam int STS_LO_LO = 12;  localparam int STS_LO_W = 20;
    localparam int STS_HI_LO = 48;  localparam int STS_HI_W = 2;
    localparam int CFG_REV_LO = 4;  localparam int CFG_REV_W = 8;
    localparam int CFG_HI_LO = 16;  localparam int CFG_HI_W = 8;

    // subword range touched by the spanning status field
    localparam int STS_LO_LSUB = STS_LO_LO / BUS_W;
    localparam int STS_LO_HSUB = (STS_LO_LO + STS_LO_W - 1) / BUS_W;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/wsub_decode.sv
module wsub_decode #(
    parameter int ADDR_W = 6,
    parameter int STEP   = 2,
    parameter int BASE   = 0,
    parameter int NSUB   = 4
) (
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output logic [NSUB-1:0]   hit
);
    timeunit 1ns;
    timeprecision 1ps;

    for (genvar i = 0; i < NSUB; i++) begin : g_sub
        assign hit[i] = sel && (addr == ADDR_W'(BASE + i * STEP));
    end
endmodule

// File: rtl/wsub_field.sv
module wsub_field #(
    parameter int BUS_W    = 16,
    parameter int W        = 8,
    parameter int OFF      = 0,
    parameter bit REVERSED = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] biten,
    output logic [W-1:0]     value
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [W-1:0] d_sl, b_sl, d_f, b_f, nxt;

    // bus slice after shifting down by the subword offset
    assign d_sl = wdata[OFF +: W];
    assign b_sl = biten[OFF +: W];

    if (REVERSED) begin : g_rev
        for (genvar j = 0; j < W; j++) begin : g_bit
            assign d_f[j] = d_sl[W-1-j];
            assign b_f[j] = b_sl[W-1-j];
        end
    end else begin : g_fwd
        assign d_f = d_sl;
        assign b_f = b_sl;
    end

    assign nxt = (value & ~b_f) | (d_f & b_f);

    always_ff @(posedge clk) begin
        if (rst)     value <= '0;
        else if (we) value <= nxt;
    end
endmodule

// File: rtl/wsub_rdmux.sv
module wsub_rdmux #(
    parameter int REG_W = 64,
    parameter int BUS_W = 16,
    localparam int NSUB = REG_W / BUS_W
) (
    input  logic [REG_W-1:0] img,
    input  logic [NSUB-1:0]  hit,
    output logic [BUS_W-1:0] word
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        word = '0;
        for (int i = 0; i < NSUB; i++) begin
            if (hit[i]) word = word | img[i*BUS_W +: BUS_W];
        end
    end
endmodule

// File: rtl/wsub_regblock.sv
module wsub_regblock
    import wsub_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [BUS_W-1:0]     req_wdata,
    input  logic [BUS_W-1:0]     req_biten,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [BUS_W-1:0]     rsp_rdata,
    output logic [CTL_F1_W-1:0]  ctl_f1,
    output logic [CTL_F2_W-1:0]  ctl_f2,
    output logic [CTL_F3_W-1:0]  ctl_f3,
    output logic [CTL_F4_W-1:0]  ctl_f4,
    output logic [CFG_REV_W-1:0] cfg_rev,
    output logic [CFG_HI_W-1:0]  cfg_hi,
    input  logic [STS_LO_W-1:0]  sts_lo_in,
    input  logic [STS_HI_W-1:0]  sts_hi_in,
    output logic                 sts_lo_acc
);
    timeunit 1ns;
    timeprecision 1ps;

    bus_state_e state_q, state_d;
    logic accept;
    logic [BUS_W-1:0] rd_q, rd_word, ctl_word, sts_word, cfg_word;

    assign accept = (state_q == ST_IDLE) && req_valid;

    // ---------------- state machine ----------------
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;  // accept
            ST_RESP: if (rsp_ready) state_d = ST_IDLE;  // retire
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        rsp_rdata = rd_q;
    end

    // ---------------- subword decode ----------------
    logic [CTL_NSUB-1:0] ctl_hit, ctl_wr, ctl_rd;
    logic [STS_NSUB-1:0] sts_hit, sts_rd;
    logic [CFG_NSUB-1:0] cfg_hit, cfg_wr, cfg_rd;

    wsub_decode #(.ADDR_W(ADDR_W), .STEP(BUS_BYTES), .BASE(CTL_BASE), .NSUB(CTL_NSUB))
        u_dec_ctl (.sel(accept), .addr(req_addr), .hit(ctl_hit));
    wsub_decode #(.ADDR_W(ADDR_W), .STEP(BUS_BYTES), .BASE(STS_BASE), .NSUB(STS_NSUB))
        u_dec_sts (.sel(accept), .addr(req_addr), .hit(sts_hit));
    wsub_decode #(.ADDR_W(ADDR_W), .STEP(BUS_BYTES), .BASE(CFG_BASE), .NSUB(CFG_NSUB))
        u_dec_cfg (.sel(accept), .addr(req_addr), .hit(cfg_hit));

    assign ctl_wr = ctl_hit & {CTL_NSUB{req_write}};
    assign ctl_rd = ctl_hit & {CTL_NSUB{!req_write}};
    assign sts_rd = sts_hit & {STS_NSUB{!req_write}};
    assign cfg_wr = cfg_hit & {CFG_NSUB{req_write}};
    assign cfg_rd = cfg_hit & {CFG_NSUB{!req_write}};

    // access pulse: OR of every subword strobe the field touches
    assign sts_lo_acc = |sts_hit[STS_LO_HSUB:STS_LO_LSUB];

    // ---------------- writable fields ----------------
    wsub_field #(.BUS_W(BUS_W), .W(CTL_F1_W), .OFF(CTL_F1_LO % BUS_W), .REVERSED(1'b0))
        u_ctl_f1 (.clk(clk), .rst(rst), .we(ctl_wr[CTL_F1_LO / BUS_W]),
                  .wdata(req_wdata), .biten(req_biten), .value(ctl_f1));
    wsub_field #(.BUS_W(BUS_W), .W(CTL_F2_W), .OFF(CTL_F2_LO % BUS_W), .REVERSED(1'b0))
        u_ctl_f2 (.clk(clk), .rst(rst), .we(ctl_wr[CTL_F2_LO / BUS_W]),
                  .wdata(req_wdata), .biten(req_biten), .value(ctl_f2));
    wsub_field #(.BUS_W(BUS_W), .W(CTL_F3_W), .OFF(CTL_F3_LO % BUS_W), .REVERSED(1'b0))
        u_ctl_f3 (.clk(clk), .rst(rst), .we(ctl_wr[CTL_F3_LO / BUS_W]),
                  .wdata(req_wdata), .biten(req_biten), .value(ctl_f3));
    wsub_field #(.BUS_W(BUS_W), .W(CTL_F4_W), .OFF(CTL_F4_LO % BUS_W), .REVERSED(1'b0))
        u_ctl_f4 (.clk(clk), .rst(rst), .we(ctl_wr[CTL_F4_LO / BUS_W]),
                  .wdata(req_wdata), .biten(req_biten), .value(ctl_f4));
    wsub_field #(.BUS_W(BUS_W), .W(CFG_REV_W), .OFF(CFG_REV_LO % BUS_W), .REVERSED(1'b1))
        u_cfg_rev (.clk(clk), .rst(rst), .we(cfg_wr[CFG_REV_LO / BUS_W]),
                   .wdata(req_wdata), .biten(req_biten), .value(cfg_rev));
    wsub_field #(.BUS_W(BUS_W), .W(CFG_HI_W), .OFF(CFG_HI_LO % BUS_W), .REVERSED(1'b0))
        u_cfg_hi (.clk(clk), .rst(rst), .we(cfg_wr[CFG_HI_LO / BUS_W]),
                  .wdata(req_wdata), .biten(req_biten), .value(cfg_hi));

    // ---------------- readback images ----------------
    logic [CTL_W-1:0] ctl_img;
    logic [STS_W-1:0] sts_img;
    logic [CFG_W-1:0] cfg_img;

    always_comb begin
        ctl_img = '0;
        ctl_img[CTL_F1_LO +: CTL_F1_W] = ctl_f1;
        ctl_img[CTL_F2_LO +: CTL_F2_W] = ctl_f2;
        ctl_img[CTL_F3_LO +: CTL_F3_W] = ctl_f3;
        ctl_img[CTL_F4_LO +: CTL_F4_W] = ctl_f4;
        sts_img = '0;
        sts_img[STS_LO_LO +: STS_LO_W] = sts_lo_in;
        sts_img[STS_HI_LO +: STS_HI_W] = sts_hi_in;
        cfg_img = '0;
        for (int j = 0; j < CFG_REV_W; j++) cfg_img[CFG_REV_LO + j] = cfg_rev[CFG_REV_W-1-j];
        cfg_img[CFG_HI_LO +: CFG_HI_W] = cfg_hi;
    end

    wsub_rdmux #(.REG_W(CTL_W), .BUS_W(BUS_W)) u_rd_ctl (.img(ctl_img), .hit(ctl_rd), .word(ctl_word));
    wsub_rdmux #(.REG_W(STS_W), .BUS_W(BUS_W)) u_rd_sts (.img(sts_img), .hit(sts_rd), .word(sts_word));
    wsub_rdmux #(.REG_W(CFG_W), .BUS_W(BUS_W)) u_rd_cfg (.img(cfg_img), .hit(cfg_rd), .word(cfg_word));

    assign rd_word = ctl_word | sts_word | cfg_word;

    always_ff @(posedge clk) begin
        if (rst)         rd_q <= '0;
        else if (accept) rd_q <= rd_word;
    end
endmodule

// File: rtl/wsub_regblock_chk.sv
module wsub_regblock_chk
    import wsub_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic                req_write,
    input logic                rsp_valid,
    input logic                rsp_ready,
    input logic [BUS_W-1:0]    rsp_rdata,
    input logic [CTL_F1_W-1:0] ctl_f1,
    input logic [CFG_HI_W-1:0] cfg_hi,
    input logic                sts_lo_acc
);
    timeunit 1ns;
    timeprecision 1ps;

    // R9
    accept_to_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && !req_ready && $stable(rsp_rdata)));

    // R9
    rsp_retire_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready) |=> req_ready);

    // R8
    acc_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        sts_lo_acc |-> (req_valid && req_ready));

    // R2
    field_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready && req_write) |=> ($stable(ctl_f1) && $stable(cfg_hi)));
endmodule

bind wsub_regblock wsub_regblock_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .ctl_f1(ctl_f1), .cfg_hi(cfg_hi), .sts_lo_acc(sts_lo_acc)
);

// File: tb/wsub_regblock_tb_top.sv
module wsub_regblock_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
    logic [5:0]  req_addr = '0;
    logic [15:0] req_wdata = '0, req_biten = '0;
    logic        req_ready, rsp_valid, sts_lo_acc;
    logic [15:0] rsp_rdata;
    logic [7:0]  ctl_f1, ctl_f4, cfg_rev, cfg_hi;
    logic [2:0]  ctl_f2;
    logic [0:0]  ctl_f3;
    logic [19:0] sts_lo_in = '0;
    logic [1:0]  sts_hi_in = '0;

    int n_chk = 0, n_fail = 0, acc_cnt = 0;
    logic [63:0] ctl_m = '0;
    logic [31:0] cfg_m = '0;
    localparam logic [63:0] CTL_MASK = 64'h0000_FF10_0000_70FF;
    localparam logic [31:0] CFG_MASK = 32'h00FF_0FF0;

    always #2.5ns clk = ~clk;

    wsub_regblock dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_biten(req_biten), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_rdata(rsp_rdata), .ctl_f1(ctl_f1), .ctl_f2(ctl_f2), .ctl_f3(ctl_f3),
        .ctl_f4(ctl_f4), .cfg_rev(cfg_rev), .cfg_hi(cfg_hi), .sts_lo_in(sts_lo_in),
        .sts_hi_in(sts_hi_in), .sts_lo_acc(sts_lo_acc)
    );

    always @(posedge clk) if (!rst && sts_lo_acc) acc_cnt++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [5:0] a, input logic [15:0] d,
                        input logic [15:0] be, output logic [15:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_biten = be;
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata;
    endtask

    // bench model of a write (R2, R3, R7, R10)
    task automatic model_wr(input logic [5:0] a, input logic [15:0] d, input logic [15:0] be);
        logic [15:0] s;
        if (a < 6'd8 && a[0] == 1'b0) begin
            s = ctl_m[a[2:1]*16 +: 16];
            ctl_m[a[2:1]*16 +: 16] = ((s & ~be) | (d & be)) & CTL_MASK[a[2:1]*16 +: 16];
        end else if (a == 6'd16 || a == 6'd18) begin
            s = cfg_m[a[1]*16 +: 16];
            cfg_m[a[1]*16 +: 16] = ((s & ~be) | (d & be)) & CFG_MASK[a[1]*16 +: 16];
        end
    endtask

    function automatic logic [63:0] exp_rd(input logic [5:0] a);
        logic [63:0] simg;
        simg = (64'(sts_lo_in) << 12) | (64'(sts_hi_in) << 48);
        if (a < 6'd8 && a[0] == 1'b0)    return 64'(ctl_m[a[2:1]*16 +: 16]);
        if (a >= 6'd8 && a < 6'd16 && a[0] == 1'b0) return 64'(simg[a[2:1]*16 +: 16]);
        if (a == 6'd16 || a == 6'd18)    return 64'(cfg_m[a[1]*16 +: 16]);
        return 64'h0;
    endfunction

    task automatic check_outs(input string req);
        logic [7:0] rv;
        for (int j = 0; j < 8; j++) rv[j] = cfg_m[11-j];
        chk({req, " ctl_f1"}, 64'(ctl_f1), 64'(ctl_m[7:0]));
        chk({req, " ctl_f2"}, 64'(ctl_f2), 64'(ctl_m[14:12]));
        chk({req, " ctl_f3"}, 64'(ctl_f3), 64'(ctl_m[36]));
        chk({req, " ctl_f4"}, 64'(ctl_f4), 64'(ctl_m[47:40]));
        chk({req, " cfg_rev"}, 64'(cfg_rev), 64'(rv));
        chk({req, " cfg_hi"}, 64'(cfg_hi), 64'(cfg_m[23:16]));
    endtask

    task automatic wr_chk(input logic [5:0] a, input logic [15:0] d, input logic [15:0] be, input string req);
        logic [15:0] r;
        xfer(1'b1, a, d, be, r);
        model_wr(a, d, be);
        chk({req, " write rdata"}, 64'(r), 64'h0);
        check_outs(req);
    endtask

    task automatic rd_chk(input logic [5:0] a, input string req);
        logic [15:0] r;
        xfer(1'b0, a, 16'h0, 16'h0, r);
        chk($sformatf("%s read @%02h", req, a), 64'(r), exp_rd(a));
    endtask

    initial begin : watchdog
        #500_000ns;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] r, held;
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 req_ready", 64'(req_ready), 64'h1);
        chk("R1 rsp_valid", 64'(rsp_valid), 64'h0);
        check_outs("R1");

        // R4 worked example
        wr_chk(6'h00, 16'h1234, 16'hFFFF, "R4");
        wr_chk(6'h02, 16'h5678, 16'hFFFF, "R4");
        wr_chk(6'h04, 16'h9ABC, 16'hFFFF, "R4");
        wr_chk(6'h06, 16'hDEF1, 16'hFFFF, "R4");
        chk("R4 f1", 64'(ctl_f1), 64'h34);
        chk("R4 f2", 64'(ctl_f2), 64'h1);
        chk("R4 f3", 64'(ctl_f3), 64'h1);
        chk("R4 f4", 64'(ctl_f4), 64'h9A);
        xfer(1'b0, 6'h00, 0, 0, r); chk("R4 rd 0", 64'(r), 64'h1034);
        xfer(1'b0, 6'h02, 0, 0, r); chk("R4 rd 2", 64'(r), 64'h0000);
        xfer(1'b0, 6'h04, 0, 0, r); chk("R4 rd 4", 64'(r), 64'h9A10);
        xfer(1'b0, 6'h06, 0, 0, r); chk("R4 rd 6", 64'(r), 64'h0000);

        // R3 partial bit enable: low nibble of f1 only
        wr_chk(6'h00, 16'h00FF, 16'h000F, "R3");
        chk("R3 f1", 64'(ctl_f1), 64'h3F);

        // R6 reversed field
        wr_chk(6'h10, 16'h0010, 16'hFFFF, "R6");
        chk("R6 bit4->7", 64'(cfg_rev), 64'h80);
        wr_chk(6'h10, 16'h0030, 16'hFFFF, "R6");
        chk("R6 bits", 64'(cfg_rev), 64'hC0);
        rd_chk(6'h10, "R6");
        wr_chk(6'h12, 16'h12AB, 16'hFFFF, "R6");
        rd_chk(6'h12, "R6");

        // R2 R3 sweep over writable subwords with mixed enables
        for (int k = 0; k < 48; k++) begin
            logic [5:0] a;
            logic [15:0] d, be;
            case (k % 6)
                0: a = 6'h00; 1: a = 6'h02; 2: a = 6'h04;
                3: a = 6'h06; 4: a = 6'h10; default: a = 6'h12;
            endcase
            d  = 16'(k * 16'h3B1D) ^ 16'hA5C3;
            be = (k % 3 == 0) ? 16'hFFFF : (d ^ 16'hF0F0);
            wr_chk(a, d, be, "R2/R3 sweep");
            rd_chk(6'h00, "R2"); rd_chk(6'h04, "R2"); rd_chk(6'h10, "R2"); rd_chk(6'h12, "R2");
        end

        // R5 spanning read-only field
        sts_lo_in = 20'hABCDE; sts_hi_in = 2'd3;
        xfer(1'b0, 6'h08, 0, 0, r); chk("R5 rd 8", 64'(r), 64'hE000);
        xfer(1'b0, 6'h0A, 0, 0, r); chk("R5 rd A", 64'(r), 64'hABCD);
        xfer(1'b0, 6'h0C, 0, 0, r); chk("R5 rd C", 64'(r), 64'h0000);
        xfer(1'b0, 6'h0E, 0, 0, r); chk("R5 rd E", 64'(r), 64'h0003);
        for (int k = 0; k < 12; k++) begin
            sts_lo_in = 20'(k * 20'h1F3A7 + 5);
            sts_hi_in = 2'(k);
            for (int s = 0; s < 4; s++) rd_chk(6'(8 + 2 * s), "R5 sweep");
        end

        // R10 writes to status ignored
        wr_chk(6'h08, 16'hFFFF, 16'hFFFF, "R10");
        wr_chk(6'h0A, 16'hFFFF, 16'hFFFF, "R10");
        rd_chk(6'h08, "R10"); rd_chk(6'h0A, "R10");

        // R7 unmapped and odd addresses
        for (int k = 0; k < 8; k++) begin
            logic [5:0] a;
            case (k)
                0: a = 6'h01; 1: a = 6'h05; 2: a = 6'h09; 3: a = 6'h11;
                4: a = 6'h14; 5: a = 6'h20; 6: a = 6'h3E; default: a = 6'h13;
            endcase
            wr_chk(a, 16'hFFFF, 16'hFFFF, "R7");
            rd_chk(a, "R7");
        end

        // R8 access pulse per touching subword
        base = acc_cnt;
        xfer(1'b0, 6'h08, 0, 0, r);
        xfer(1'b0, 6'h0A, 0, 0, r);
        @(negedge clk);
        chk("R8 two reads", 64'(acc_cnt - base), 64'd2);
        xfer(1'b0, 6'h0C, 0, 0, r);
        xfer(1'b0, 6'h0E, 0, 0, r);
        xfer(1'b0, 6'h00, 0, 0, r);
        @(negedge clk);
        chk("R8 other subwords", 64'(acc_cnt - base), 64'd2);
        xfer(1'b1, 6'h0A, 16'h1, 16'h1, r);
        @(negedge clk);
        chk("R8 write", 64'(acc_cnt - base), 64'd3);

        // R9 stalled response holds data
        sts_lo_in = 20'h12345; sts_hi_in = 2'd1;
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 6'h0A;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 rsp_valid", 64'(rsp_valid), 64'h1);
        held = rsp_rdata;
        chk("R9 data", 64'(held), 64'h1234);
        sts_lo_in = 20'h0;
        repeat (3) @(negedge clk);
        chk("R9 hold valid", 64'(rsp_valid), 64'h1);
        chk("R9 hold ready", 64'(req_ready), 64'h0);
        chk("R9 hold data", 64'(rsp_rdata), 64'(held));
        rsp_ready = 1'b1;
        @(negedge clk);
        chk("R9 retire valid", 64'(rsp_valid), 64'h0);
        chk("R9 retire ready", 64'(req_ready), 64'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule